// File: doc/BRIEF.md
# Accumulator Countdown Delay Sequencer

This block carries out a delay instruction for a small accumulator-based core. When an idle request arrives it captures a loop count P and the current accumulator value. It then stays busy for a fixed number of microcycles that depends on both values. The delay comes from counting the accumulator itself down to zero. First the captured accumulator value is drained. Then, for each unit of P, a short loop head runs and the accumulator is wound through a full wrap back to zero. The core does nothing else while the block is busy.

A microcycle-enable input stands for the core's internal step rate, so only enabled clock cycles move the sequence forward. At the end a single-cycle completion pulse is issued. The accumulator output, now zero, can be written back into the core's register file.

Top module: `acc_delay_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done and acc_out are all 0.
- R2: A start pulse seen while idle captures param and acc_in at that clock edge. From the next cycle busy is 1 and acc_out shows the captured accumulator.
- R3: busy stays high for exactly OVERHEAD + ACC_STEP·AC + P·(LOOP_EXTRA + ACC_STEP·2^DATA_W) counted microcycles. With the defaults (13, 2, 2, 8 bits) this is 13 + 2·AC + 2·P + 512·P.
- R4: The shortest delay is OVERHEAD microcycles, when AC = P = 0. The longest is reached when both are all ones: 131,593 at 8 bits and 553 at 4 bits.
- R5: A microcycle is counted only on a clock edge where ucyc_en is 1. When ucyc_en is 0, busy, done and acc_out keep their values.
- R6: After the fixed overhead, acc_out falls by one for every ACC_STEP counted microcycles until it reaches zero. In each P loop, after LOOP_EXTRA microcycles, acc_out steps from 0 to all ones and keeps falling back to 0, wrapping modulo 2^DATA_W.
- R7: A start pulse while busy is 1 is ignored. The delay length and the accumulator sequence of the run in progress do not change.
- R8: done is a one-cycle pulse. It is high in the cycle right after the last counted microcycle, which is the first cycle in which busy is 0 again.
- R9: acc_out is 0 while done is high, and it stays 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ucyc_en | input | 1 | Microcycle enable; the sequence advances only on enabled edges |
| start | input | 1 | Request to begin a delay; taken only when idle |
| param | input | DATA_W | Loop count P |
| acc_in | input | DATA_W | Accumulator value at start |
| busy | output | 1 | High while the delay runs |
| done | output | 1 | One-cycle pulse when the delay ends |
| acc_out | output | DATA_W | Live accumulator value, zero after completion |

## Verification
The checker takes it for granted that start is the only way to load new values and that param and acc_in matter only on the edge where an idle start is taken. It makes no assumption about how often ucyc_en is high. The stimulus holds start for a single cycle and changes param and acc_in only together with it, apart from a deliberate start raised in the middle of a run. Every value of P and AC is swept at a reduced width, and three enable patterns are applied: always on, every other cycle, and one cycle in three.

// File: rtl/dly_seq_pkg.sv
package dly_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIXED = 2'd1,
    ST_LOOP  = 2'd2,
    ST_DRAIN = 2'd3
  } dly_state_t;
endpackage

// File: rtl/dly_down_cnt.sv
module dly_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] q,
  output logic         is_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (dec) begin
      q <= q - 1'b1;
    end
  end

  assign is_zero = (q == '0);
endmodule

// File: rtl/dly_acc_unit.sv
module dly_acc_unit #(
  parameter int W        = 8,
  parameter int ACC_STEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] acc_q,
  output logic         acc_zero,
  output logic         last_step
);
  logic step_tick;

  generate
    if (ACC_STEP > 1) begin : g_sub
      localparam int SW = $clog2(ACC_STEP);
      localparam logic [SW-1:0] SUB_END = SW'(ACC_STEP - 1);
      logic [SW-1:0] sub_q;

      always_ff @(posedge clk) begin
        if (rst || load) begin
          sub_q <= '0;
        end else if (run) begin
          sub_q <= (sub_q == SUB_END) ? '0 : sub_q + 1'b1;
        end
      end

      assign step_tick = run && (sub_q == SUB_END);
    end else begin : g_nosub
      assign step_tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= load_val;
    end else if (step_tick) begin
      acc_q <= acc_q - 1'b1;
    end
  end

  assign acc_zero  = (acc_q == '0);
  assign last_step = step_tick && (acc_q == W'(1));
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_seq_pkg::*;
#(
  parameter int OVERHEAD   = 13,
  parameter int LOOP_EXTRA = 2,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          en,
  input  logic          acc_zero,
  input  logic          acc_last,
  input  logic          fix_zero,
  input  logic          p_zero,
  output logic          take,
  output logic          fix_load,
  output logic [CW-1:0] fix_val,
  output logic          fix_dec,
  output logic          p_dec,
  output logic          drain_run,
  output logic          busy_q,
  output logic          done_q
);
  localparam logic [CW-1:0] FIX_INIT  = CW'(OVERHEAD - 1);
  localparam logic [CW-1:0] LOOP_INIT = CW'(LOOP_EXTRA - 1);

  dly_state_t state_q, state_d;
  logic       fin;

  always_comb begin
    state_d   = state_q;
    take      = 1'b0;
    fix_load  = 1'b0;
    fix_val   = FIX_INIT;
    fix_dec   = 1'b0;
    p_dec     = 1'b0;
    drain_run = 1'b0;
    fin       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          take     = 1'b1;
          fix_load = 1'b1;
          state_d  = ST_FIXED;
        end
      end
      ST_FIXED: begin
        if (en) begin
          if (!fix_zero) begin
            fix_dec = 1'b1;
          end else if (!acc_zero) begin
            state_d = ST_DRAIN;
          end else if (!p_zero) begin
            fix_load = 1'b1;
            fix_val  = LOOP_INIT;
            state_d  = ST_LOOP;
          end else begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_LOOP: begin
        if (en) begin
          if (!fix_zero) begin
            fix_dec = 1'b1;
          end else begin
            p_dec   = 1'b1;
            state_d = ST_DRAIN;
          end
        end
      end
      default: begin
        drain_run = en;
        if (acc_last) begin
          if (!p_zero) begin
            fix_load = 1'b1;
            fix_val  = LOOP_INIT;
            state_d  = ST_LOOP;
          end else begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
      done_q  <= fin;
    end
  end
endmodule

// File: rtl/acc_delay_seq.sv
module acc_delay_seq #(
  parameter int DATA_W     = 8,
  parameter int OVERHEAD   = 13,
  parameter int ACC_STEP   = 2,
  parameter int LOOP_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ucyc_en,
  input  logic              start,
  input  logic [DATA_W-1:0] param,
  input  logic [DATA_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out
);
  localparam int FIX_MAX = (OVERHEAD > LOOP_EXTRA) ? OVERHEAD : LOOP_EXTRA;
  localparam int CW      = $clog2(FIX_MAX) + 1;

  logic          take, fix_load, fix_dec, p_dec, drain_run;
  logic [CW-1:0] fix_val, fix_q;
  logic          fix_zero, p_zero, acc_zero, acc_last;
  logic [DATA_W-1:0] p_q;

  dly_ctrl #(
    .OVERHEAD  (OVERHEAD),
    .LOOP_EXTRA(LOOP_EXTRA),
    .CW        (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .en       (ucyc_en),
    .acc_zero (acc_zero),
    .acc_last (acc_last),
    .fix_zero (fix_zero),
    .p_zero   (p_zero),
    .take     (take),
    .fix_load (fix_load),
    .fix_val  (fix_val),
    .fix_dec  (fix_dec),
    .p_dec    (p_dec),
    .drain_run(drain_run),
    .busy_q   (busy),
    .done_q   (done)
  );

  dly_down_cnt #(.W(CW)) u_fix (
    .clk     (clk),
    .rst     (rst),
    .load    (fix_load),
    .load_val(fix_val),
    .dec     (fix_dec),
    .q       (fix_q),
    .is_zero (fix_zero)
  );

  dly_down_cnt #(.W(DATA_W)) u_loops (
    .clk     (clk),
    .rst     (rst),
    .load    (take),
    .load_val(param),
    .dec     (p_dec),
    .q       (p_q),
    .is_zero (p_zero)
  );

  dly_acc_unit #(.W(DATA_W), .ACC_STEP(ACC_STEP)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .load     (take),
    .load_val (acc_in),
    .run      (drain_run),
    .acc_q    (acc_out),
    .acc_zero (acc_zero),
    .last_step(acc_last)
  );
endmodule

// File: rtl/acc_delay_seq_chk.sv
module acc_delay_seq_chk #(
  parameter int DATA_W     = 8,
  parameter int OVERHEAD   = 13,
  parameter int ACC_STEP   = 2,
  parameter int LOOP_EXTRA = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ucyc_en,
  input logic              start,
  input logic [DATA_W-1:0] param,
  input logic [DATA_W-1:0] acc_in,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] acc_out
);
  localparam int LOOP_LEN = LOOP_EXTRA + ACC_STEP * (2 ** DATA_W);

  int unsigned seen_q, want_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 0;
      want_q <= 0;
    end else if (start && !busy) begin
      seen_q <= 0;
      want_q <= OVERHEAD + ACC_STEP * int'(acc_in) + int'(param) * LOOP_LEN;
    end else if (busy && ucyc_en) begin
      seen_q <= seen_q + 1;
    end
  end

  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen_q == want_q));

  p_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !ucyc_en) |=> ($stable(acc_out) && busy && !done));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (acc_out != $past(acc_out)))
      |-> (acc_out == DATA_W'($past(acc_out) - 1'b1)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (acc_out == '0));
endmodule

bind acc_delay_seq acc_delay_seq_chk #(
  .DATA_W    (DATA_W),
  .OVERHEAD  (OVERHEAD),
  .ACC_STEP  (ACC_STEP),
  .LOOP_EXTRA(LOOP_EXTRA)
) u_chk (.*);

// File: tb/tb_acc_delay_seq.sv
module tb_acc_delay_seq;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ucyc_en = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] param = '0;
  logic [W-1:0] acc_in = '0;
  logic         busy, done;
  logic [W-1:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  acc_delay_seq #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .ucyc_en(ucyc_en), .start(start),
    .param(param), .acc_in(acc_in),
    .busy(busy), .done(done), .acc_out(acc_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit en_at(input int mode, input int k);
    case (mode)
      0: return 1'b1;
      1: return (k % 2) == 0;
      default: return (k % 3) == 2;
    endcase
  endfunction

  task automatic run_one(input int ac, input int p, input int mode, input bit poke);
    int n = 13 + 2 * ac + p * (2 + 2 * (1 << W));
    int c = 0;
    int k = 0;
    @(negedge clk);
    acc_in = W'(ac);
    param  = W'(p);
    start  = 1'b1;
    ucyc_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(acc_out == W'(ac), "R2 captured accumulator", int'(acc_out), ac);
    while (busy) begin
      if (c >= 13 && c <= 13 + 2 * ac && ((c - 13) % 2) == 0)
        chk(acc_out == W'(ac - (c - 13) / 2), "R6 drain value", int'(acc_out), ac - (c - 13) / 2);
      if (p > 0 && c == 13 + 2 * ac + 4)
        chk(acc_out == W'(MAXV), "R6 wrap value", int'(acc_out), MAXV);
      if (c > 0 && c < n)
        chk(done == 1'b0, "R8 no early done", int'(done), 0);
      if (poke && c == 5 && k < 40) begin
        start  = 1'b1;
        acc_in = ~W'(ac);
        param  = ~W'(p);
      end else begin
        start = 1'b0;
      end
      ucyc_en = en_at(mode, k);
      if (ucyc_en) c++;
      k++;
      if (k > 4 * n + 50) begin
        chk(1'b0, "R3 run did not end", c, n);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    ucyc_en = 1'b0;
    chk(c == n, "R3 counted length", c, n);
    chk(done == 1'b1, "R8 done after last microcycle", int'(done), 1);
    chk(acc_out == '0, "R9 zero at done", int'(acc_out), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    chk(acc_out == '0, "R9 zero held", int'(acc_out), 0);
    chk(busy == 1'b0, "R7 no restart from ignored start", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && acc_out == '0, "R1 during reset",
        int'({busy, done, acc_out}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && acc_out == '0, "R1 after reset",
        int'({busy, done, acc_out}), 0);

    // R5: enable held low keeps the block frozen mid-run
    acc_in = W'(3); param = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1 && acc_out == W'(3), "R5 frozen without enable",
        int'(acc_out), 3);
    ucyc_en = 1'b1;
    repeat (19) @(negedge clk);
    chk(done == 1'b1 && acc_out == '0, "R5 resumes after enable", int'(done), 1);
    ucyc_en = 1'b0;
    @(negedge clk);

    // R4: extremes of the small configuration
    run_one(0, 0, 0, 1'b0);
    run_one(MAXV, MAXV, 0, 1'b0);
    chk(13 + 2 * MAXV + MAXV * (2 + 2 * (1 << W)) == 553, "R4 max length", 553, 553);

    // R3, R6, R7: full sweep with continuous enable, poking start mid-run
    for (int p = 0; p <= MAXV; p++)
      for (int a = 0; a <= MAXV; a++)
        run_one(a, p, 0, (a % 3) == 0);

    // R5: sparse enable patterns
    for (int m = 1; m <= 2; m++)
      for (int p = 0; p <= MAXV; p += 7)
        for (int a = 0; a <= MAXV; a += 5)
          run_one(a, p, m, 1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule